// File: doc/BRIEF.md
# I2C Arbitration-Loss Fault Injector

This block sits on an open-drain I2C bus next to a master under test and disturbs one transfer on purpose. Software arms it with an interference length in microseconds. The injector then watches SCL. On the first falling SCL edge after arming, it holds SDA low for the programmed time and then lets it go. The master reads back bits that differ from the ones it drove, so a correct master must report lost arbitration. The disturbance is clearest when the master sends an address with many '1' bits, because every forced-low '1' shows up as a mismatch.

The injector fires once per arming and then returns to idle. A pending wait can be cancelled before the trigger. SCL passes through a two-flop synchronizer before edge detection. The trigger is taken only from SCL and never from SDA activity. This matters because an SDA-based trigger would only test bus-busy detection, not arbitration loss. The injector never drives SCL. SDA is driven through an active-high pull-down enable and is never driven to '1'.

The state machine has three states:
- `ST_IDLE` goes to `ST_WAIT` on an arm request.
- `ST_WAIT` goes back to `ST_IDLE` on cancel.
- `ST_WAIT` goes to `ST_IDLE` with done on a falling SCL edge when the duration is zero.
- `ST_WAIT` goes to `ST_PULL` on a falling SCL edge when the duration is nonzero.
- `ST_PULL` goes to `ST_IDLE` with done when the timer expires.

Top module: `arb_disturber`

## Requirements
- R1: After reset `busy_o`, `done_o` and `sda_pull_o` are all 0.
- R2: A one-cycle `arm_i` in idle latches `dur_us_i` and sets `busy_o` from the next cycle. `sda_pull_o` stays 0 while SCL does not fall.
- R3: The trigger is the first falling edge of `scl_i` after arming. The edge passes a two-flop synchronizer and an edge register, so `sda_pull_o` rises in the third clock cycle after `scl_i` goes low.
- R4: `sda_pull_o` stays 1 for exactly `dur_us * CLK_PER_US` clock cycles and then returns to 0.
- R5: `done_o` is a single-cycle pulse in the cycle `sda_pull_o` is released. `busy_o` is 0 in that same cycle.
- R6: With a latched duration of 0, `done_o` pulses in the third cycle after `scl_i` falls, and `sda_pull_o` never rises.
- R7: `cancel_i` while waiting returns to idle with no `done_o` and no SDA pull. Cancel wins over a trigger seen in the same cycle. Cancel is ignored while SDA is being pulled.
- R8: `arm_i` while `busy_o` is 1 is ignored, and the pulse length keeps the first duration.
- R9: The injection is one-shot. SCL edges after completion cause no further pull or `done_o`.
- R10: A falling SCL edge that happens before arming does not trigger, and a rising SCL edge never triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | One-cycle request that latches the duration and starts waiting |
| dur_us_i | input | DUR_W | Interference length in microseconds |
| cancel_i | input | 1 | Aborts a pending wait |
| scl_i | input | 1 | Sampled bus clock line |
| busy_o | output | 1 | High from arming until release or cancel |
| done_o | output | 1 | One-cycle completion pulse |
| sda_pull_o | output | 1 | Pull-down enable for SDA (1 = pull low) |

## Verification
The bench builds the block with `CLK_PER_US = 3` and `DUR_W = 5`. With these values, a pulse of up to twelve microseconds lasts only a few dozen cycles. This lets many random durations, including zero and the multi-microsecond prescaler wrap, be timed cycle by cycle in one short run. The small prescaler also puts the boundary where the last microsecond ends, and the same-cycle cancel-versus-trigger race, within a handful of cycles of the SCL edge.

// File: rtl/arbd_pkg.sv
package arbd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_PULL = 2'd2
    } arbd_state_e;
endpackage

// File: rtl/arbd_sync.sv
module arbd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/arbd_us_timer.sv
module arbd_us_timer #(
    parameter int CLK_PER_US = 50,
    parameter int DUR_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DUR_W-1:0] dur_i,
    input  logic             run_i,
    output logic             expire_o
);
    localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

    logic [PRE_W-1:0] pre_q;
    logic [DUR_W-1:0] us_left_q;
    logic             pre_wrap;

    assign pre_wrap = (pre_q == PRE_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q     <= '0;
            us_left_q <= '0;
        end else if (load_i) begin
            pre_q     <= '0;
            us_left_q <= dur_i;
        end else if (run_i) begin
            if (pre_wrap) begin
                pre_q     <= '0;
                us_left_q <= us_left_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expire_o = run_i && pre_wrap && (us_left_q == DUR_W'(1));

    // R4: the microsecond count never runs out while the pull is active
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (us_left_q != '0));
endmodule

// File: rtl/arb_disturber.sv
module arb_disturber
    import arbd_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int DUR_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [DUR_W-1:0] dur_us_i,
    input  logic             cancel_i,
    input  logic             scl_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             sda_pull_o
);
    arbd_state_e      state_q, state_d;
    logic [DUR_W-1:0] dur_q;
    logic             scl_s, scl_prev_q, scl_fall;
    logic             timer_load, timer_expire, done_d, done_q;

    arbd_sync #(.STAGES(2), .RST_VAL(1'b1)) i_scl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (scl_i),
        .q_o   (scl_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scl_prev_q <= 1'b1;
        else        scl_prev_q <= scl_s;
    end

    assign scl_fall = scl_prev_q && !scl_s;

    arbd_us_timer #(.CLK_PER_US(CLK_PER_US), .DUR_W(DUR_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (timer_load),
        .dur_i    (dur_q),
        .run_i    (state_q == ST_PULL),
        .expire_o (timer_expire)
    );

    // next state and transition strobes
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        done_d     = 1'b0;
        unique case (state_q)
            ST_IDLE: if (arm_i) state_d = ST_WAIT;
            ST_WAIT: begin
                if (cancel_i) begin
                    state_d = ST_IDLE;
                end else if (scl_fall) begin
                    if (dur_q == '0) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        state_d    = ST_PULL;
                        timer_load = 1'b1;
                    end
                end
            end
            ST_PULL: begin
                if (timer_expire) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dur_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
            if (state_q == ST_IDLE && arm_i) dur_q <= dur_us_i;
        end
    end

    // outputs
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        sda_pull_o = (state_q == ST_PULL);
        done_o     = done_q;
    end

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r3_pull_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(scl_fall && state_q == ST_WAIT));

    a_r7_cancel_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && cancel_i) |=> (state_q == ST_IDLE && !done_o));

    a_r8_arm_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && arm_i) |=> $stable(dur_q));

    a_r6_zero_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> (dur_q != '0));
endmodule

// File: tb/test_arb_disturber.sv
module test_arb_disturber;
    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 3;
    localparam int DW         = 5;
    localparam int WATCHDOG   = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm_i = 1'b0;
    logic [DW-1:0] dur_us_i = '0;
    logic          cancel_i = 1'b0;
    logic          scl_i = 1'b1;
    logic          busy_o, done_o, sda_pull_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arb_disturber #(.CLK_PER_US(CPU), .DUR_W(DW)) i_arb_disturber (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .dur_us_i(dur_us_i),
        .cancel_i(cancel_i), .scl_i(scl_i), .busy_o(busy_o),
        .done_o(done_o), .sda_pull_o(sda_pull_o)
    );

    function automatic int exp_pull_len(int d);
        return d * CPU;
    endfunction

    function automatic int exp_done_idx(int d);
        return 3 + d * CPU;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic arm(int d);
        dur_us_i = DW'(d);
        arm_i = 1'b1;
        step();
        arm_i = 1'b0;
    endtask

    // drop SCL, toggle it like a master clock, and time the response
    task automatic run_fall(int d, int cancel_at, string req);
        int first_pull = -1, pulls = 0, done_at = -1, dones = 0, busy_at_done = -1;
        int win = exp_done_idx(d) + 10;
        scl_i = 1'b0;
        for (int i = 1; i <= win; i++) begin
            cancel_i = (i == cancel_at);
            step();
            if (sda_pull_o) begin
                pulls++;
                if (first_pull < 0) first_pull = i;
            end
            if (done_o) begin
                dones++;
                if (done_at < 0) begin done_at = i; busy_at_done = busy_o; end
            end
            if (i % 2 == 0) scl_i = ~scl_i;
        end
        cancel_i = 1'b0;
        scl_i = 1'b1;
        if (d > 0) check(first_pull == 3, {req, " R3 pull start"}, first_pull, 3);
        check(pulls == exp_pull_len(d), {req, " R4 pull length"}, pulls, exp_pull_len(d));
        check(done_at == exp_done_idx(d), {req, " R5/R6 done cycle"}, done_at, exp_done_idx(d));
        check(busy_at_done == 0, {req, " R5 busy at done"}, busy_at_done, 0);
        check(dones == 1, {req, " R9 one-shot"}, dones, 1);
        repeat (3) step();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd1234);
        repeat (3) step();
        check(busy_o == 0 && done_o == 0 && sda_pull_o == 0, "R1 reset outputs",
              {busy_o, done_o, sda_pull_o}, 0);
        rst_n = 1'b1;
        repeat (2) step();

        // R2: arm, SCL held high: busy, no pull
        arm(2);
        check(busy_o == 1, "R2 busy after arm", busy_o, 1);
        begin
            int pulls = 0;
            repeat (8) begin step(); pulls += sda_pull_o; end
            check(pulls == 0, "R2 no pull without SCL fall", pulls, 0);
        end
        run_fall(2, 0, "directed d=2");

        // R6: zero duration
        arm(0);
        run_fall(0, 0, "directed d=0");

        // R7: cancel while waiting
        arm(4);
        step();
        cancel_i = 1'b1; step(); cancel_i = 1'b0;
        check(busy_o == 0, "R7 cancel idles", busy_o, 0);
        begin
            int act = 0;
            scl_i = 1'b0;
            repeat (10) begin step(); act += sda_pull_o + done_o; end
            scl_i = 1'b1;
            check(act == 0, "R7 no pull or done after cancel", act, 0);
        end
        repeat (3) step();

        // R7: cancel in the same cycle as the trigger wins (trigger seen before edge 3)
        arm(4);
        begin
            int act = 0;
            scl_i = 1'b0;
            step(); step();
            cancel_i = 1'b1; step(); cancel_i = 1'b0;
            act += sda_pull_o + done_o + busy_o;
            repeat (8) begin step(); act += sda_pull_o + done_o; end
            scl_i = 1'b1;
            check(act == 0, "R7 cancel beats trigger", act, 0);
        end
        repeat (3) step();

        // R7: cancel during the pull is ignored
        arm(3);
        run_fall(3, 5, "cancel in pull R7");

        // R10: fall before arming, then rise, do not trigger
        scl_i = 1'b0;
        repeat (4) step();
        arm(2);
        begin
            int act = 0;
            repeat (5) begin step(); act += sda_pull_o; end
            scl_i = 1'b1;
            repeat (5) begin step(); act += sda_pull_o; end
            check(act == 0, "R10 stale fall and rise ignored", act, 0);
            check(busy_o == 1, "R10 still waiting", busy_o, 1);
        end
        run_fall(2, 0, "after stale fall R10");

        // random trials, some with an ignored re-arm (R8)
        for (int t = 0; t < 30; t++) begin
            int d, gap, other;
            d = int'($urandom_range(12, 0));
            gap = int'($urandom_range(5, 0));
            other = int'($urandom_range(31, 0));
            arm(d);
            repeat (gap) step();
            if (t % 2 == 0) arm(other);
            check(busy_o == 1, "R8 busy while waiting", busy_o, 1);
            run_fall(d, 0, "random R8");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule